// File: doc/BRIEF.md
# Unaligned Byte-Stream Transfer Splitter

The splitter turns one buffer transfer into the sequence of bus accesses that a device data port needs. A transfer is given by a start byte address, a byte length and a direction. The block breaks it into byte, halfword and word accesses, so that most of the bytes move as naturally aligned 32-bit words. It sends bytes or halfwords only to reach word alignment at the front and to finish the last bytes at the end. Lane order inside a word is little-endian, so byte `addr+k` occupies bits `8k+7:8k`.

Each access is presented with a valid/ready handshake. It carries the size code, the buffer address of its first byte, the number of bytes still outstanding, and the direction captured with the request. The same sequence serves reads and writes, because the direction is only carried along. A single-cycle done pulse closes every request, including an empty one. The block then returns to idle and can take the next request.

Top module: `xfer_splitter`

## Requirements
- R1: After reset, and after a reset applied in the middle of a request, `req_ready` is 1 and `acc_valid` and `done` are 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1, and `req_ready` is 1 only while idle. Address, length and direction are sampled in that cycle. Changing the request inputs, or holding `req_valid` high while busy, leaves the access sequence unchanged.
- R3: When the start address is odd and the length is nonzero, the first access is a byte (size code 0) at the start address. The position then moves up by one and the remaining count drops by one.
- R4: If the position is not a multiple of four after that step and two or more bytes remain, the next access is a halfword (size code 1).
- R5: While four or more bytes remain, word accesses (size code 2) follow one another. Each word is at an address that is a multiple of four, and the position advances by four per word.
- R6: In the tail, a halfword is issued first if two or more bytes remain, and then a single byte if one is left.
- R7: A zero-length request raises `done` in the cycle after it is taken and issues no access.
- R8: An access keeps `acc_valid` high, with its size, address and remaining count unchanged, until `acc_ready` is sampled high. The next access appears in the cycle right after the handshake.
- R9: `done` is high for exactly one cycle, in the cycle after the handshake of the last access. The block is idle in the following cycle.
- R10: `acc_addr` is the buffer byte position of the current access, and `acc_rem` counts the bytes still to move including that access. `acc_dir` carries the captured direction. Across a request, every byte of the range is covered exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address of the buffer |
| req_len | input | LEN_W | Byte count of the transfer |
| req_dir | input | 1 | Direction, 1 = write toward device, 0 = read |
| acc_valid | output | 1 | Access presented |
| acc_ready | input | 1 | Device port takes the access |
| acc_size | output | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr | output | ADDR_W | Buffer address of the access |
| acc_rem | output | LEN_W | Bytes outstanding including this access |
| acc_dir | output | 1 | Captured direction |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The bench targets every start alignment (offsets 0 to 3 and higher odd and even offsets) combined with lengths of 0, 1, 2, 3, 4, 5 and larger. This covers requests that end before alignment is reached, such as an odd start with one or two bytes. A design that chose the size from the length alone would issue misaligned words. A design that skipped the alignment halfword would emit two bytes, and an off-by-one remaining count would overrun the buffer. The bench checks this through per-byte coverage counts.

Back-pressure on `acc_ready` exposes accesses that advance without a handshake. Request inputs scrambled while busy expose late capture. The zero-length case catches a block that waits for an access that never comes, or that issues a spurious one.

// File: rtl/xfs_pkg.sv
package xfs_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfs_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } xfs_state_e;

    // byte count moved by one access of the given size
    function automatic logic [2:0] xfs_bytes(input logic [1:0] sz);
        case (sz)
            SZ_HALF: xfs_bytes = 3'd2;
            SZ_WORD: xfs_bytes = 3'd4;
            default: xfs_bytes = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/xfs_size_pick.sv
// Chooses the size of the next access from the low address bits and the
// remaining count. Odd position -> byte; position at 2 mod 4 -> halfword
// when two bytes remain; aligned -> word, then halfword/byte tail.
module xfs_size_pick
    import xfs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [1:0]       addr_lo,
    input  logic [LEN_W-1:0] len,
    output xfs_size_e        size
);
    localparam logic [LEN_W-1:0] TWO  = LEN_W'(2);
    localparam logic [LEN_W-1:0] FOUR = LEN_W'(4);

    logic two_left;
    logic four_left;

    always_comb begin
        two_left  = (len >= TWO);
        four_left = (len >= FOUR);
        if (addr_lo[0]) begin
            size = SZ_BYTE;                     // prologue byte
        end else if (addr_lo[1]) begin
            size = two_left ? SZ_HALF : SZ_BYTE; // prologue halfword
        end else if (four_left) begin
            size = SZ_WORD;                     // aligned body
        end else if (two_left) begin
            size = SZ_HALF;                     // epilogue halfword
        end else begin
            size = SZ_BYTE;                     // epilogue byte
        end
    end

endmodule

// File: rtl/xfs_advance.sv
// Moves the transfer cursor past one access.
module xfs_advance
    import xfs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  xfs_size_e         size,
    output logic [ADDR_W-1:0] addr_nx,
    output logic [LEN_W-1:0]  len_nx,
    output logic              last
);
    logic [2:0] step;

    always_comb begin
        step    = xfs_bytes(size);
        addr_nx = addr + {{(ADDR_W-3){1'b0}}, step};
        len_nx  = len - {{(LEN_W-3){1'b0}}, step};
        last    = (len_nx == '0);
    end

endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
    import xfs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_dir,
    output logic              acc_valid,
    input  logic              acc_ready,
    output logic [1:0]        acc_size,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LEN_W-1:0]  acc_rem,
    output logic              acc_dir,
    output logic              done
);
    typedef struct packed {
        xfs_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              dir;
    } cursor_t;

    cursor_t cur_q, cur_d;

    xfs_size_e         pick_size;
    logic [ADDR_W-1:0] addr_step;
    logic [LEN_W-1:0]  len_step;
    logic              step_last;

    xfs_size_pick #(.LEN_W(LEN_W)) u_pick (
        .addr_lo (cur_q.addr[1:0]),
        .len     (cur_q.len),
        .size    (pick_size)
    );

    xfs_advance #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_adv (
        .addr    (cur_q.addr),
        .len     (cur_q.len),
        .size    (pick_size),
        .addr_nx (addr_step),
        .len_nx  (len_step),
        .last    (step_last)
    );

    always_comb begin
        cur_d = cur_q;
        case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    cur_d.addr = req_addr;
                    cur_d.len  = req_len;
                    cur_d.dir  = req_dir;
                    cur_d.st   = (req_len == '0) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (acc_ready) begin
                    cur_d.addr = addr_step;
                    cur_d.len  = len_step;
                    if (step_last) begin
                        cur_d.st = ST_DONE;
                    end
                end
            end
            default: cur_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, addr: '0, len: '0, dir: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign req_ready = (cur_q.st == ST_IDLE);
    assign acc_valid = (cur_q.st == ST_RUN);
    assign acc_size  = pick_size;
    assign acc_addr  = cur_q.addr;
    assign acc_rem   = cur_q.len;
    assign acc_dir   = cur_q.dir;
    assign done      = (cur_q.st == ST_DONE);

    // R8: access held until handshake
    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_ready |=> acc_valid && $stable(acc_addr)
            && $stable(acc_size) && $stable(acc_rem) && $stable(acc_dir));

    // R5: words only at word boundaries with four bytes left
    a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_size == SZ_WORD |-> acc_addr[1:0] == 2'b00
            && acc_rem >= LEN_W'(4));

    // R10: an access never reaches past the buffer end
    a_r10_fits: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> acc_rem >= LEN_W'(xfs_bytes(acc_size)) && acc_size != 2'd3);

    // R10: cursor advances by the size of the accepted access
    a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_ready && acc_rem > LEN_W'(xfs_bytes(acc_size))
        |=> acc_valid
            && acc_addr == $past(acc_addr) + ADDR_W'(xfs_bytes($past(acc_size)))
            && acc_rem == $past(acc_rem) - LEN_W'(xfs_bytes($past(acc_size))));

    // R9: done is a single-cycle pulse followed by idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R9: final handshake leads to done
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_ready && acc_rem == LEN_W'(xfs_bytes(acc_size)) |=> done);

    // R7: empty request finishes without an access
    a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_len == '0 |=> done && !acc_valid);

    // R2: never ready while an access is outstanding
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> !req_ready && !done);

endmodule

// File: tb/tb_xfer_splitter.sv
`timescale 1ns/1ps
module tb_xfer_splitter;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam logic [31:0] BASE = 32'h0000_0100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_dir = 1'b0;
    logic              acc_valid;
    logic              acc_ready = 1'b0;
    logic [1:0]        acc_size;
    logic [ADDR_W-1:0] acc_addr;
    logic [LEN_W-1:0]  acc_rem;
    logic              acc_dir;
    logic              done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xfer_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_len, .req_dir,
        .acc_valid, .acc_ready, .acc_size, .acc_addr, .acc_rem, .acc_dir, .done
    );

    // expected access list
    logic [31:0] exp_a [64];
    logic [1:0]  exp_s [64];
    logic [15:0] exp_r [64];
    string       exp_t [64];
    int          n_exp;
    int          touched [256];

    // {dir, stall, poke, offset, length}
    localparam int NVEC = 14;
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 6'd0, 16'd16},
        {1'b0, 1'b0, 1'b0, 6'd1, 16'd13},
        {1'b1, 1'b0, 1'b0, 6'd2, 16'd10},
        {1'b0, 1'b0, 1'b0, 6'd3, 16'd9},
        {1'b0, 1'b0, 1'b0, 6'd1, 16'd1},
        {1'b1, 1'b0, 1'b0, 6'd1, 16'd2},
        {1'b0, 1'b0, 1'b0, 6'd2, 16'd1},
        {1'b0, 1'b1, 1'b0, 6'd0, 16'd3},
        {1'b0, 1'b0, 1'b1, 6'd3, 16'd0},
        {1'b0, 1'b1, 1'b0, 6'd5, 16'd40},
        {1'b1, 1'b1, 1'b1, 6'd6, 16'd7},
        {1'b0, 1'b0, 1'b0, 6'd7, 16'd100},
        {1'b1, 1'b0, 1'b0, 6'd0, 16'd4},
        {1'b0, 1'b1, 1'b1, 6'd3, 16'd5}
    };

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [1:0] s,
                        input logic [15:0] r, input string t);
        exp_a[n_exp] = a; exp_s[n_exp] = s; exp_r[n_exp] = r; exp_t[n_exp] = t;
        n_exp++;
    endtask

    // sequential reference: prologue byte, prologue half, words, tail
    task automatic gen_exp(input logic [31:0] a0, input int len);
        logic [31:0] a = a0;
        int l = len;
        n_exp = 0;
        if (a[0] && l > 0) begin push(a, 2'd0, 16'(l), "R3"); a += 1; l -= 1; end
        if (a[1:0] != 2'b00 && l >= 2) begin push(a, 2'd1, 16'(l), "R4"); a += 2; l -= 2; end
        while (l >= 4) begin push(a, 2'd2, 16'(l), "R5"); a += 4; l -= 4; end
        if (l >= 2) begin push(a, 2'd1, 16'(l), "R6"); a += 2; l -= 2; end
        if (l > 0) push(a, 2'd0, 16'(l), "R6");
    endtask

    task automatic run_req(input logic [5:0] off, input int len, input logic dir,
                           input logic stall, input logic poke);
        logic [31:0] a0;
        int idx, bad;
        bit held, first, fin;
        logic [31:0] sv_a;
        logic [1:0]  sv_s;
        logic [15:0] sv_r;
        a0 = BASE + 32'(off);
        gen_exp(a0, len);
        for (int i = 0; i < 256; i++) touched[i] = 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R2", "ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a0; req_len = 16'(len); req_dir = dir;
        idx = 0; held = 0; first = 1; fin = 0;
        sv_a = '0; sv_s = '0; sv_r = '0;
        for (int c = 0; c < 400 && !fin; c++) begin
            @(negedge clk);
            if (first) begin
                check(req_ready == 1'b0, "R2", "busy after accept", 64'(req_ready), 64'd0);
                req_valid = poke; req_addr = ~a0; req_len = 16'd3; req_dir = ~dir;
                first = 0;
            end
            if (done) begin
                check(idx == n_exp && !acc_valid, "R9", "done after last access",
                      64'(idx), 64'(n_exp));
                fin = 1; req_valid = 1'b0; acc_ready = 1'b0;
            end else if (idx == n_exp) begin
                check(1'b0, (n_exp == 0) ? "R7" : "R9", "done missing",
                      64'(done), 64'd1);
                fin = 1; req_valid = 1'b0; acc_ready = 1'b0;
            end else if (acc_valid) begin
                if (!held) begin
                    check(acc_size == exp_s[idx] && acc_addr == exp_a[idx]
                          && acc_rem == exp_r[idx] && acc_dir == dir, exp_t[idx],
                          "access {size,addr,rem}",
                          {12'(acc_size), 32'(acc_addr), 16'(acc_rem), 4'(acc_dir)},
                          {12'(exp_s[idx]), 32'(exp_a[idx]), 16'(exp_r[idx]), 4'(dir)});
                end else begin
                    check(acc_size == sv_s && acc_addr == sv_a && acc_rem == sv_r,
                          "R8", "stalled access stable",
                          {12'(acc_size), 32'(acc_addr), 16'(acc_rem), 4'd0},
                          {12'(sv_s), 32'(sv_a), 16'(sv_r), 4'd0});
                end
                if (stall && !held) begin
                    acc_ready = 1'b0; held = 1;
                    sv_a = acc_addr; sv_s = acc_size; sv_r = acc_rem;
                end else begin
                    acc_ready = 1'b1; held = 0;
                    for (int k = 0; k < (1 << acc_size); k++)
                        touched[8'(acc_addr - BASE) + k]++;
                    idx++;
                end
            end else begin
                check(1'b0, "R8", "access gap", 64'(acc_valid), 64'd1);
                fin = 1; req_valid = 1'b0; acc_ready = 1'b0;
            end
        end
        if (!fin) check(1'b0, "R9", "request never finished", 64'd0, 64'd1);
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            if (touched[i] != ((i >= int'(off) && i < int'(off) + len) ? 1 : 0)) bad++;
        end
        check(bad == 0, "R10", "byte coverage mismatches", 64'(bad), 64'd0);
        acc_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1 && acc_valid == 1'b0 && done == 1'b0, "R1",
              "reset state {ready,valid,done}",
              {61'd0, req_ready, acc_valid, done}, 64'b100);

        for (int v = 0; v < NVEC; v++) begin
            run_req(VEC[v][21:16], int'(VEC[v][15:0]), VEC[v][24], VEC[v][23], VEC[v][22]);
        end

        // R1 reset in the middle of a request
        @(negedge clk);
        req_valid = 1'b1; req_addr = BASE + 32'd1; req_len = 16'd30; req_dir = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; acc_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(acc_valid == 1'b1, "R1", "mid-request busy before reset", 64'(acc_valid), 64'd1);
        rst_n = 1'b0; acc_ready = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && acc_valid == 1'b0 && done == 1'b0, "R1",
              "state after mid-run reset", {61'd0, req_ready, acc_valid, done}, 64'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // fresh request after the aborted one is sequenced from scratch (R3)
        run_req(6'd3, 3, 1'b0, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule